// File: doc/BRIEF.md
# Double-Precision Pair Shifter

This block shifts an accumulator pair, an upper register and a lower register, as one 30-bit quantity. Each register is 16 bits wide. It carries 15 data bits, and its sign sits in bit 14. The upper register's 15 data bits form the high half of the pair and the lower register's form the low half. Bits cross between the halves with no gap.

A 19-bit shift word sets what the block does. It holds a two's-complement count: a positive count shifts left and a negative count shifts right. It also holds a signedness selector and a pre-clear field. The pre-clear field can zero either register, or both, before the shift.

A one-cycle start strobe loads the result into the output registers. A done pulse follows on the next cycle. Between starts, the outputs hold their last value.

Top module: `pair_shifter`

## Requirements
- R1: While reset is high, and on the first edge after it, `a_out` and `l_out` are zero and `done` is low.
- R2: A start sampled at a rising edge loads the result into `a_out`/`l_out` at that edge and raises `done` for exactly that one following cycle. Without a start, `done` is low and both outputs keep their value.
- R3: Field positions in `shift_word`:
  - the count occupies bits 8..0;
  - the unsigned selector is bit 9;
  - the pre-clear field is bits 11..10;
  - bits 18..12 have no effect on the result.
- R4: A positive count n shifts the pair {a_in[14:0], l_in[14:0]} left by n, with zeros entering at the bottom. Bit 14 of the lower register moves into bit 0 of the upper register.
- R5: A negative count -n with the unsigned selector set to 1 shifts the pair right by n, with zeros entering at the top.
- R6: A negative count with the unsigned selector at 0 shifts right and copies the pair's top bit (a_in[14]) into every vacated position. For left shifts the selector has no effect.
- R7: Pre-clear codes are 00 none, 01 zero the upper register, 10 zero the lower register, and 11 zero both. The clear is applied before shifting.
- R8: A count magnitude of 30 or more gives a pair of all zeros. The exception is a signed right shift, which gives all copies of the sign bit. Counts run from -256 to +255.
- R9: Input bit 15 of either register is ignored. Output bit 15 of each register repeats that register's bit 14.
- R10: A count of zero leaves the (pre-cleared) pair unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Perform one shift at this edge |
| shift_word | input | 19 | Shift control word |
| a_in | input | 16 | Upper register contents |
| l_in | input | 16 | Lower register contents |
| a_out | output | 16 | Shifted upper register |
| l_out | output | 16 | Shifted lower register |
| done | output | 1 | One-cycle pulse after start |

## Verification
The bench targets the seam between the two halves. A design that shifted each register alone would drop the bit that should cross from the lower half into the upper, or from the upper into the lower. It also drives counts of 29, 30, -29, -30, -256 and +255. A barrel shifter without a saturation check would wrap the count modulo 32 and give partial results instead of all zeros or all sign bits. Other tests cover:
- signed against unsigned right shifts of a negative pair, which catches a fill bit taken from the wrong place or a stray input bit 15;
- all four pre-clear codes, which catches swapped encodings.

// File: rtl/pair_shift_pkg.sv
package pair_shift_pkg;

  // Field layout of the shift word; the count sits at the bottom so that
  // address modification can reach it.
  localparam int CNT_W   = 9;
  localparam int CNT_LSB = 0;
  localparam int UNS_BIT = 9;
  localparam int PC_LSB  = 10;

  typedef enum logic [1:0] {
    PC_NONE  = 2'b00,
    PC_UPPER = 2'b01,
    PC_LOWER = 2'b10,
    PC_BOTH  = 2'b11
  } preclr_e;

  typedef struct packed {
    preclr_e          pc;
    logic             uns;
    logic             right;
    logic [CNT_W-1:0] mag;
  } shift_ctl_t;

endpackage

// File: rtl/pshift_decode.sv
module pshift_decode
  import pair_shift_pkg::*;
(
  input  logic [CNT_W-1:0] cnt_field,
  input  logic             uns_field,
  input  logic [1:0]       pc_field,
  output shift_ctl_t       ctl
);

  logic [CNT_W-1:0] neg_cnt;

  always_comb begin
    neg_cnt   = (~cnt_field) + {{(CNT_W-1){1'b0}}, 1'b1};
    ctl.pc    = preclr_e'(pc_field);
    ctl.uns   = uns_field;
    ctl.right = cnt_field[CNT_W-1];
    // magnitude is unsigned; the most negative count maps to 2**(CNT_W-1)
    ctl.mag   = cnt_field[CNT_W-1] ? neg_cnt : cnt_field;
  end

endmodule

// File: rtl/pshift_preclear.sv
module pshift_preclear
  import pair_shift_pkg::*;
#(
  parameter int HALF_W = 15
) (
  input  logic [HALF_W-1:0] up_in,
  input  logic [HALF_W-1:0] lo_in,
  input  preclr_e           pc,
  output logic [HALF_W-1:0] up_out,
  output logic [HALF_W-1:0] lo_out
);

  always_comb begin
    up_out = up_in;
    lo_out = lo_in;
    unique case (pc)
      PC_UPPER: up_out = '0;
      PC_LOWER: lo_out = '0;
      PC_BOTH: begin
        up_out = '0;
        lo_out = '0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pshift_barrel.sv
module pshift_barrel #(
  parameter int PAIR_W = 30,
  parameter int MAG_W  = 9
) (
  input  logic [PAIR_W-1:0] x,
  input  logic              right,
  input  logic              arith,
  input  logic [MAG_W-1:0]  mag,
  output logic [PAIR_W-1:0] y
);

  localparam int STG = $clog2(PAIR_W);

  logic              fill;
  logic              sat;
  logic [PAIR_W-1:0] x_or;
  logic [PAIR_W-1:0] stg [STG+1];
  logic [PAIR_W-1:0] y_r;
  logic [PAIR_W-1:0] y_or;

  assign fill = right & arith & x[PAIR_W-1];
  assign sat  = (mag >= MAG_W'(PAIR_W));

  // Left shifts run through the same right-shifting network on a
  // bit-reversed copy.
  genvar i;
  generate
    for (i = 0; i < PAIR_W; i++) begin : g_rev
      assign x_or[i] = right ? x[i] : x[PAIR_W-1-i];
      assign y[i]    = right ? y_r[i] : y_r[PAIR_W-1-i];
    end
  endgenerate

  assign stg[0] = x_or;

  genvar k;
  generate
    for (k = 0; k < STG; k++) begin : g_stage
      localparam int SH = 1 << k;
      if (SH < PAIR_W) begin : g_sh
        assign stg[k+1] = mag[k] ? {{SH{fill}}, stg[k][PAIR_W-1:SH]} : stg[k];
      end else begin : g_full
        assign stg[k+1] = mag[k] ? {PAIR_W{fill}} : stg[k];
      end
    end
  endgenerate

  assign y_or = stg[STG];
  assign y_r  = sat ? {PAIR_W{fill}} : y_or;

endmodule

// File: rtl/pair_shifter.sv
module pair_shifter
  import pair_shift_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int HALF_W = 15,
  parameter int WORD_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] shift_word,
  input  logic [REG_W-1:0]  a_in,
  input  logic [REG_W-1:0]  l_in,
  output logic [REG_W-1:0]  a_out,
  output logic [REG_W-1:0]  l_out,
  output logic              done
);

  localparam int PAIR_W = 2 * HALF_W;

  shift_ctl_t        ctl;
  logic [HALF_W-1:0] a_c;
  logic [HALF_W-1:0] l_c;
  logic [PAIR_W-1:0] pair_y;
  logic              unused_bits;

  assign unused_bits = ^{shift_word[WORD_W-1:PC_LSB+2], a_in[REG_W-1:HALF_W], l_in[REG_W-1:HALF_W]};

  pshift_decode u_dec (
    .cnt_field (shift_word[CNT_LSB +: CNT_W]),
    .uns_field (shift_word[UNS_BIT]),
    .pc_field  (shift_word[PC_LSB +: 2]),
    .ctl       (ctl)
  );

  pshift_preclear #(.HALF_W(HALF_W)) u_clr (
    .up_in  (a_in[HALF_W-1:0]),
    .lo_in  (l_in[HALF_W-1:0]),
    .pc     (ctl.pc),
    .up_out (a_c),
    .lo_out (l_c)
  );

  pshift_barrel #(.PAIR_W(PAIR_W), .MAG_W(CNT_W)) u_bar (
    .x     ({a_c, l_c}),
    .right (ctl.right),
    .arith (~ctl.uns),
    .mag   (ctl.mag),
    .y     (pair_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out <= '0;
      l_out <= '0;
      done  <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        a_out <= {{(REG_W-HALF_W){pair_y[PAIR_W-1]}}, pair_y[PAIR_W-1:HALF_W]};
        l_out <= {{(REG_W-HALF_W){pair_y[HALF_W-1]}}, pair_y[HALF_W-1:0]};
      end
    end
  end

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst) start |=> done); // R2
  AST_DONE_ONLY: assert property (@(posedge clk) disable iff (rst) !start |=> !done); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !start |=> ($stable(a_out) && $stable(l_out))); // R2
  AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (rst) (start && shift_word[PC_LSB +: 2] == 2'b11) |=> (a_out == '0 && l_out == '0)); // R7
  AST_SAT_ZERO: assert property (@(posedge clk) disable iff (rst) (start && ctl.mag >= CNT_W'(PAIR_W) && (!ctl.right || ctl.uns)) |=> (a_out == '0 && l_out == '0)); // R8
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst) (start && shift_word[CNT_LSB +: CNT_W] == '0 && shift_word[PC_LSB +: 2] == 2'b00) |=> (a_out[HALF_W-1:0] == $past(a_in[HALF_W-1:0]) && l_out[HALF_W-1:0] == $past(l_in[HALF_W-1:0]))); // R10

endmodule

// File: tb/pair_shifter_bench.sv
module pair_shifter_bench;

  typedef struct packed {
    logic [3:0]  req;
    logic [6:0]  up;
    logic [1:0]  pp;
    logic        u;
    logic [8:0]  cnt;
    logic [15:0] a;
    logic [15:0] l;
    logic [15:0] ea;
    logic [15:0] el;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{4'd4,  7'h3A, 2'd0, 1'b0, 9'h001, 16'h0001, 16'h4000, 16'h0003, 16'h0000}, // R4 seam crossing
    '{4'd5,  7'h3A, 2'd0, 1'b1, 9'h1FF, 16'h4000, 16'h0000, 16'h2000, 16'h0000}, // R5
    '{4'd6,  7'h3A, 2'd0, 1'b0, 9'h1FF, 16'h4000, 16'h0001, 16'hE000, 16'h0000}, // R6
    '{4'd5,  7'h3A, 2'd0, 1'b0, 9'h1F1, 16'h0005, 16'h0000, 16'h0000, 16'h0005}, // R5 right 15
    '{4'd4,  7'h3A, 2'd0, 1'b0, 9'h00F, 16'h1234, 16'h0ABC, 16'h0ABC, 16'h0000}, // R4 left 15
    '{4'd4,  7'h3A, 2'd0, 1'b0, 9'h01D, 16'h0000, 16'h0001, 16'hC000, 16'h0000}, // R4 left 29
    '{4'd8,  7'h3A, 2'd0, 1'b0, 9'h01E, 16'h7FFF, 16'h7FFF, 16'h0000, 16'h0000}, // R8 left 30
    '{4'd8,  7'h3A, 2'd0, 1'b0, 9'h1E2, 16'h4000, 16'h0000, 16'hFFFF, 16'hFFFF}, // R8 signed right 30
    '{4'd8,  7'h3A, 2'd0, 1'b1, 9'h100, 16'h7FFF, 16'h7FFF, 16'h0000, 16'h0000}, // R8 right 256
    '{4'd8,  7'h3A, 2'd0, 1'b0, 9'h0FF, 16'h7FFF, 16'h7FFF, 16'h0000, 16'h0000}, // R8 left 255
    '{4'd7,  7'h3A, 2'd1, 1'b0, 9'h000, 16'h1111, 16'h2222, 16'h0000, 16'h2222}, // R7 clear upper
    '{4'd7,  7'h3A, 2'd2, 1'b0, 9'h001, 16'h0001, 16'h7FFF, 16'h0002, 16'h0000}, // R7 clear lower
    '{4'd7,  7'h3A, 2'd3, 1'b0, 9'h1FF, 16'h4000, 16'h4000, 16'h0000, 16'h0000}, // R7 clear both
    '{4'd9,  7'h3A, 2'd0, 1'b0, 9'h1FF, 16'h8001, 16'h0000, 16'h0000, 16'hC000}, // R9
    '{4'd6,  7'h3A, 2'd0, 1'b1, 9'h001, 16'h2000, 16'h0000, 16'hC000, 16'h0000}, // R6 U ignored left
    '{4'd3,  7'h7F, 2'd0, 1'b0, 9'h002, 16'h0001, 16'h0000, 16'h0004, 16'h0000}, // R3 upper bits
    '{4'd8,  7'h3A, 2'd0, 1'b0, 9'h1E3, 16'h4000, 16'h0000, 16'hFFFF, 16'hFFFF}, // R8 signed right 29
    '{4'd5,  7'h3A, 2'd0, 1'b1, 9'h1E3, 16'h4000, 16'h0000, 16'h0000, 16'h0001}, // R5 right 29
    '{4'd10, 7'h00, 2'd0, 1'b0, 9'h000, 16'h2A55, 16'h5AA5, 16'h2A55, 16'hDAA5}  // R10 zero count
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [18:0] shift_word = '0;
  logic [15:0] a_in = '0;
  logic [15:0] l_in = '0;
  logic [15:0] a_out;
  logic [15:0] l_out;
  logic        done;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pair_shifter u_pair_shifter (
    .clk(clk), .rst(rst), .start(start), .shift_word(shift_word),
    .a_in(a_in), .l_in(l_in), .a_out(a_out), .l_out(l_out), .done(done)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    shift_word = {v.up, v.pp, v.u, v.cnt};
    a_in = v.a;
    l_in = v.l;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset a_out", a_out, 16'h0);
    check("R1 reset l_out", l_out, 16'h0);
    check("R1 reset done", {15'b0, done}, 16'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check($sformatf("R%0d vec%0d a_out", VEC[i].req, i), a_out, VEC[i].ea);
      check($sformatf("R%0d vec%0d l_out", VEC[i].req, i), l_out, VEC[i].el);
      check($sformatf("R2 vec%0d done", i), {15'b0, done}, 16'h1);
    end

    // R2: idle cycles hold the outputs and keep done low
    @(negedge clk);
    shift_word = 19'h00001;
    a_in = 16'h7FFF;
    l_in = 16'h7FFF;
    repeat (3) @(negedge clk);
    check("R2 hold a_out", a_out, 16'h2A55);
    check("R2 hold l_out", l_out, 16'hDAA5);
    check("R2 done low", {15'b0, done}, 16'h0);

    // R1: reset in mid-run clears the outputs
    apply(VEC[0]);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset a_out", a_out, 16'h0);
    check("R1 mid reset l_out", l_out, 16'h0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule